// File: doc/BRIEF.md
# Multiprocessor Wake-Up Serial Receiver

This block recovers characters from an asynchronous, non-return-to-zero serial line. An external divider supplies a one-cycle sample tick at eight times the bit rate. The receiver resynchronises the line and waits for a high-to-low transition. It then votes on three samples near the centre of every bit and assembles a character of one to eight data bits, sent least significant bit first. An address bit and a parity bit may follow the data. Parity, framing, overrun and break conditions are kept as sticky error flags. The received character is presented with a ready flag that a read strobe clears.

Several receivers may share one line, with each one asleep until it sees an address frame. Two modes decide which frames count as address frames. In idle-gap mode, an address frame is one whose start edge follows at least ten bit periods of continuous high level. In tagged mode, an address frame is one whose address bit is 1. While the sleep input is set, frames that are not address frames are dropped without trace. A wake flag marks the character on the output as an address.

The controller is a state machine with seven states:
- IDLE waits for a start edge.
- START checks the start bit.
- DATA collects the data bits.
- ADDR takes the address bit.
- PARITY takes the parity bit.
- STOP checks the first stop bit.
- BREAK follows a missing stop bit.

The transitions are:
- IDLE→START on a start edge.
- START→IDLE when the start bit votes high, which is a glitch.
- START→DATA when the start bit votes low.
- DATA→ADDR, DATA→PARITY or DATA→STOP after the last data bit.
- ADDR→PARITY or ADDR→STOP after the address bit.
- PARITY→STOP after the parity bit.
- STOP→IDLE when the stop bit votes high.
- STOP→BREAK when the stop bit votes low.
- BREAK→IDLE on the first high sample.

Top module: `mpwake_rx`

## Requirements
- R1: A frame begins at a tick whose synchronised sample is low while the previous tick's sample was high. Each bit then spans 8 ticks. The data length is `char_len`+1 bits, sent least significant bit first, and the unused upper bits of `rx_data` read 0.
- R2: Each bit value is the majority of the 4th, 5th and 6th of its 8 samples, so one corrupted sample inside a bit does not change the received value.
- R3: A start bit whose vote is high is treated as a glitch. The receiver returns to IDLE, loads nothing and leaves `rx_ready` unchanged.
- R4: When `par_en`=1, a parity bit follows the data bits, or the address bit in tagged mode. Parity counts the data bits plus the address bit. `par_even`=1 requires an even total count of ones including the parity bit, and `par_even`=0 requires an odd total. A mismatch sets `err_parity`.
- R5: A first stop bit that votes low sets `err_frame`. The character is still loaded.
- R6: After a missing stop bit, 80 further consecutive low samples (10 bit periods) set `err_break`, whether or not the receiver is asleep. A high sample returns the receiver to IDLE.
- R7: A character loaded while `rx_ready` is still 1, with no read strobe in that cycle, sets `err_overrun`.
- R8: `rd_strobe` clears `rx_ready`. If a character is loaded in the same cycle, the load wins and `rx_ready` stays 1.
- R9: The four error flags stay set until `err_clr` or reset, with a new error winning over a clear in the same cycle. `err_any` is 1 exactly when any error flag is 1.
- R10: With `addr_mode`=0, a frame is an address frame when the line was sampled high for at least 80 consecutive ticks before its start edge. Reset counts as no idle time.
- R11: With `addr_mode`=1, an address bit follows the data bits, and the frame is an address frame when that bit is 1, regardless of the idle time before it.
- R12: While `sleep`=1, a frame that is not an address frame leaves `rx_data`, `rx_ready`, `wake_flag` and the parity, framing and overrun flags unchanged. Every loaded character sets `wake_flag` to its address status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| sample_tick | input | 1 | One-cycle pulse, 8 per bit period |
| char_len | input | 3 | Data length minus one |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| addr_mode | input | 1 | 0 = idle-gap wake-up, 1 = address-bit wake-up |
| sleep | input | 1 | Drop frames that are not address frames |
| rd_strobe | input | 1 | Character consumed; clears ready |
| err_clr | input | 1 | Clears the four error flags |
| rx_data | output | 8 | Last loaded character |
| rx_ready | output | 1 | New character present |
| err_parity | output | 1 | Parity mismatch seen |
| err_frame | output | 1 | Low stop bit seen |
| err_overrun | output | 1 | Character lost to an unread predecessor |
| err_break | output | 1 | Line held low after a missing stop bit |
| err_any | output | 1 | OR of the four error flags |
| wake_flag | output | 1 | Loaded character was an address frame |

## Verification
The read strobe that clears `rx_ready` and the load of a newly completed character can happen in the same clock cycle. The bench provokes this by holding `rd_strobe` high for every cycle of a frame's stop bit while the previous character is still pending, so the load cycle also sees the strobe. The result is judged correct if `rx_ready` remains 1, the new character appears, and `err_overrun` stays clear. A design that lets the clear win would drop the character.

// File: rtl/mpwake_rx_pkg.sv
package mpwake_rx_pkg;

    // Controller states of the receiver.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_ADDR,
        ST_PARITY,
        ST_STOP,
        ST_BREAK
    } rx_state_e;

    // Two-of-three majority.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/mpwake_rx_sampler.sv
module mpwake_rx_sampler
    import mpwake_rx_pkg::*;
#(
    parameter int OSR         = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IW         = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_in,
    input  logic          tick,
    input  logic [IW-1:0] idx_nxt,
    output logic          smp,
    output logic          fall,
    output logic          vote
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   prev_q;
    logic [2:0]             vs_q;

    // Resynchronise the asynchronous line; the idle level is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[SYNC_STAGES-2:0], line_in};
    end

    assign smp = chain_q[SYNC_STAGES-1];

    // Previous tick's sample, for edge detection. After reset the line
    // must be seen high once before an edge can be taken.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    prev_q <= 1'b0;
        else if (tick) prev_q <= smp;
    end

    assign fall = tick & ~smp & prev_q;

    // Capture the three centre samples of the current bit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vs_q <= 3'b111;
        end else if (tick) begin
            for (int k = 0; k < 3; k++) begin
                if (idx_nxt == IW'(OSR / 2 - 1 + k)) vs_q[k] <= smp;
            end
        end
    end

    assign vote = vote3(vs_q[0], vs_q[1], vs_q[2]);

endmodule

// File: rtl/mpwake_rx_linemon.sv
module mpwake_rx_linemon #(
    parameter int OSR       = 8,
    parameter int IDLE_BITS = 10,
    parameter int BRK_BITS  = 10,
    localparam int IDLE_T   = IDLE_BITS * OSR,
    localparam int BRK_T    = BRK_BITS * OSR,
    localparam int ICW      = $clog2(IDLE_T + 1),
    localparam int BCW      = $clog2(BRK_T + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic smp,
    input  logic brk_arm,
    output logic idle_met,
    output logic brk_hit
);

    logic [ICW-1:0] hi_cnt_q;
    logic [BCW-1:0] lo_cnt_q;

    // Run length of high samples, saturating at the idle threshold.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= '0;
        end else if (tick) begin
            if (!smp)                           hi_cnt_q <= '0;
            else if (hi_cnt_q != ICW'(IDLE_T))  hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    assign idle_met = (hi_cnt_q == ICW'(IDLE_T));

    // Low run while armed after a missing stop bit; fires once.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt_q <= '0;
        end else if (!brk_arm) begin
            lo_cnt_q <= '0;
        end else if (tick) begin
            if (smp)                            lo_cnt_q <= '0;
            else if (lo_cnt_q != BCW'(BRK_T))   lo_cnt_q <= lo_cnt_q + 1'b1;
        end
    end

    assign brk_hit = brk_arm & tick & ~smp & (lo_cnt_q == BCW'(BRK_T - 1));

endmodule

// File: rtl/mpwake_rx_shifter.sv
module mpwake_rx_shifter #(
    parameter int DW  = 8,
    localparam int LW = (DW > 1) ? $clog2(DW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          put_data,
    input  logic          put_par,
    input  logic [LW-1:0] pos,
    input  logic          bit_in,
    output logic [DW-1:0] data,
    output logic          odd_ones
);

    logic [DW-1:0] data_q;
    logic          odd_q;

    // Bits are written by position, so unused upper bits stay zero.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            odd_q  <= 1'b0;
        end else if (clr) begin
            data_q <= '0;
            odd_q  <= 1'b0;
        end else if (put_data) begin
            data_q[pos] <= bit_in;
            odd_q       <= odd_q ^ bit_in;
        end else if (put_par) begin
            odd_q       <= odd_q ^ bit_in;
        end
    end

    assign data     = data_q;
    assign odd_ones = odd_q;

endmodule

// File: rtl/mpwake_rx.sv
module mpwake_rx
    import mpwake_rx_pkg::*;
#(
    parameter int OSR         = 8,
    parameter int DW          = 8,
    parameter int IDLE_BITS   = 10,
    parameter int BRK_BITS    = 10,
    parameter int SYNC_STAGES = 2,
    localparam int LW         = (DW > 1) ? $clog2(DW) : 1,
    localparam int IW         = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_line,
    input  logic          sample_tick,
    input  logic [LW-1:0] char_len,
    input  logic          par_en,
    input  logic          par_even,
    input  logic          addr_mode,
    input  logic          sleep,
    input  logic          rd_strobe,
    input  logic          err_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_ready,
    output logic          err_parity,
    output logic          err_frame,
    output logic          err_overrun,
    output logic          err_break,
    output logic          err_any,
    output logic          wake_flag
);

    localparam logic [IW-1:0] LAST_IDX = IW'(OSR - 2);

    rx_state_e     state_q, state_d;
    logic [IW-1:0] idx_q, idx_nxt;
    logic [LW-1:0] cnt_q;
    logic          abit_q, from_idle_q;

    logic          smp, fall, vote;
    logic          idle_met, brk_hit;
    logic [DW-1:0] shift_data;
    logic          odd_ones;

    logic          in_frame, start_det, bit_end, frame_done;
    logic          addr_frame, take, perr_now;

    // ---------------- sub-blocks ----------------
    mpwake_rx_sampler #(
        .OSR         (OSR),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (rx_line),
        .tick    (sample_tick),
        .idx_nxt (idx_nxt),
        .smp     (smp),
        .fall    (fall),
        .vote    (vote)
    );

    mpwake_rx_linemon #(
        .OSR       (OSR),
        .IDLE_BITS (IDLE_BITS),
        .BRK_BITS  (BRK_BITS)
    ) u_linemon (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (sample_tick),
        .smp      (smp),
        .brk_arm  (state_q == ST_BREAK),
        .idle_met (idle_met),
        .brk_hit  (brk_hit)
    );

    mpwake_rx_shifter #(
        .DW (DW)
    ) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (start_det),
        .put_data (bit_end && (state_q == ST_DATA)),
        .put_par  (bit_end && ((state_q == ST_ADDR) || (state_q == ST_PARITY))),
        .pos      (cnt_q),
        .bit_in   (vote),
        .data     (shift_data),
        .odd_ones (odd_ones)
    );

    // ---------------- timing ----------------
    assign in_frame   = (state_q != ST_IDLE) && (state_q != ST_BREAK);
    assign idx_nxt    = in_frame ? idx_q + 1'b1 : '0;
    assign start_det  = fall && (state_q == ST_IDLE);
    assign bit_end    = sample_tick && in_frame && (idx_q == LAST_IDX);
    assign frame_done = bit_end && (state_q == ST_STOP);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_det) state_d = ST_START;
            ST_START:  if (bit_end)   state_d = vote ? ST_IDLE : ST_DATA;
            ST_DATA:   if (bit_end && (cnt_q == char_len)) begin
                           if (addr_mode)   state_d = ST_ADDR;
                           else if (par_en) state_d = ST_PARITY;
                           else             state_d = ST_STOP;
                       end
            ST_ADDR:   if (bit_end)   state_d = par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_end)   state_d = ST_STOP;
            ST_STOP:   if (bit_end)   state_d = vote ? ST_IDLE : ST_BREAK;
            ST_BREAK:  if (sample_tick && smp) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // ---------------- frame bookkeeping ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q       <= '0;
            cnt_q       <= '0;
            abit_q      <= 1'b0;
            from_idle_q <= 1'b0;
        end else begin
            if (sample_tick) idx_q <= idx_nxt;
            if (start_det) begin
                cnt_q       <= '0;
                abit_q      <= 1'b0;
                from_idle_q <= idle_met;
            end else if (bit_end && (state_q == ST_DATA)) begin
                cnt_q <= cnt_q + 1'b1;
            end else if (bit_end && (state_q == ST_ADDR)) begin
                abit_q <= vote;
            end
        end
    end

    // ---------------- outputs ----------------
    assign addr_frame = addr_mode ? abit_q : from_idle_q;
    assign take       = frame_done && (!sleep || addr_frame);
    assign perr_now   = par_en && (odd_ones == par_even);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data     <= '0;
            rx_ready    <= 1'b0;
            wake_flag   <= 1'b0;
            err_parity  <= 1'b0;
            err_frame   <= 1'b0;
            err_overrun <= 1'b0;
            err_break   <= 1'b0;
        end else begin
            if (take) begin
                rx_data   <= shift_data;
                wake_flag <= addr_frame;
                rx_ready  <= 1'b1;
            end else if (rd_strobe) begin
                rx_ready  <= 1'b0;
            end

            if (take && perr_now)                     err_parity  <= 1'b1;
            else if (err_clr)                         err_parity  <= 1'b0;

            if (take && !vote)                        err_frame   <= 1'b1;
            else if (err_clr)                         err_frame   <= 1'b0;

            if (take && rx_ready && !rd_strobe)       err_overrun <= 1'b1;
            else if (err_clr)                         err_overrun <= 1'b0;

            if (brk_hit)                              err_break   <= 1'b1;
            else if (err_clr)                         err_break   <= 1'b0;
        end
    end

    assign err_any = err_parity | err_frame | err_overrun | err_break;

endmodule

// File: rtl/mpwake_rx_sva.sv
module mpwake_rx_sva #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_line,
    input logic          rd_strobe,
    input logic          err_clr,
    input logic [DW-1:0] rx_data,
    input logic          rx_ready,
    input logic          err_parity,
    input logic          err_frame,
    input logic          err_overrun,
    input logic          err_break,
    input logic          wake_flag
);

    AST_PARITY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_parity && !err_clr) |=> err_parity); // R9

    AST_FRAME_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_frame && !err_clr) |=> err_frame); // R5

    AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rd_strobe) |=> rx_ready); // R8

    AST_DATA_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_ready); // R12

    AST_OVERRUN_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(rx_ready)); // R7

    AST_BREAK_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_break) |-> !$past(rx_line)); // R6

    AST_WAKE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_flag) |-> rx_ready); // R12

endmodule

bind mpwake_rx mpwake_rx_sva #(.DW(DW)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_line     (rx_line),
    .rd_strobe   (rd_strobe),
    .err_clr     (err_clr),
    .rx_data     (rx_data),
    .rx_ready    (rx_ready),
    .err_parity  (err_parity),
    .err_frame   (err_frame),
    .err_overrun (err_overrun),
    .err_break   (err_break),
    .wake_flag   (wake_flag)
);

// File: tb/mpwake_rx_tb.sv
`timescale 1ns/1ps
module mpwake_rx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       sample_tick = 1'b0;
    logic [2:0] char_len = 3'd7;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       addr_mode = 1'b0;
    logic       sleep = 1'b0;
    logic       rd_strobe = 1'b0;
    logic       err_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, err_parity, err_frame, err_overrun, err_break, err_any, wake_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #4 clk = ~clk;   // 125 MHz

    mpwake_rx u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_line     (rx_line),
        .sample_tick (sample_tick),
        .char_len    (char_len),
        .par_en      (par_en),
        .par_even    (par_even),
        .addr_mode   (addr_mode),
        .sleep       (sleep),
        .rd_strobe   (rd_strobe),
        .err_clr     (err_clr),
        .rx_data     (rx_data),
        .rx_ready    (rx_ready),
        .err_parity  (err_parity),
        .err_frame   (err_frame),
        .err_overrun (err_overrun),
        .err_break   (err_break),
        .err_any     (err_any),
        .wake_flag   (wake_flag)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One sample slot: line value held for 4 clocks, tick on the last.
    task automatic slot(input logic v);
        rx_line = v;
        repeat (3) @(negedge clk);
        sample_tick = 1'b1;
        @(negedge clk);
        sample_tick = 1'b0;
    endtask

    task automatic slots(input logic v, input int n);
        for (int i = 0; i < n; i++) slot(v);
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
    endtask

    function automatic logic par_bit(input logic [7:0] d, input int nb, input logic use_a,
                                     input logic a, input logic even);
        logic ones = 1'b0;
        for (int i = 0; i < nb; i++) ones ^= d[i];
        if (use_a) ones ^= a;
        return even ? ones : ~ones;
    endfunction

    function automatic logic [7:0] mask(input int nb);
        return (nb >= 8) ? 8'hFF : 8'((9'd1 << nb) - 9'd1);
    endfunction

    task automatic send_frame(input int gap, input logic [7:0] d, input int nb,
                              input logic use_a, input logic a, input logic use_p, input logic p,
                              input logic stop_v, input int glitch_bit, input logic hold_rd);
        logic bits [12];
        int   n = 0;
        slots(1'b1, gap);
        bits[n++] = 1'b0;
        for (int i = 0; i < nb; i++) bits[n++] = d[i];
        if (use_a) bits[n++] = a;
        if (use_p) bits[n++] = p;
        bits[n++] = stop_v;
        for (int b = 0; b < n; b++) begin
            if (hold_rd && b == n - 1) rd_strobe = 1'b1;
            for (int s = 0; s < 8; s++) begin
                logic v = bits[b];
                if (b == glitch_bit + 1 && s == 4) v = ~v;
                slot(v);
            end
        end
        rd_strobe = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "ready after reset", rx_ready, 0);
        chk("R1", "data after reset", rx_data, 0);
        chk("R9", "err_any after reset", err_any, 0);
        chk("R12", "wake after reset", wake_flag, 0);
    endtask

    task automatic t_basic();
        char_len = 3'd7;
        send_frame(16, 8'hA5, 8, 0, 0, 0, 0, 1, -1, 0);
        chk("R1", "8-bit data", rx_data, 8'hA5);
        chk("R1", "ready set", rx_ready, 1);
        chk("R9", "no error", err_any, 0);
        pulse_rd();
        chk("R8", "ready cleared by read", rx_ready, 0);
        chk("R8", "data kept after read", rx_data, 8'hA5);
    endtask

    task automatic t_short_len();
        char_len = 3'd4;
        send_frame(16, 8'hF6, 5, 0, 0, 0, 0, 1, -1, 0);
        chk("R1", "5-bit data, upper zero", rx_data, 8'hF6 & mask(5));
        pulse_rd();
        char_len = 3'd7;
    endtask

    task automatic t_vote();
        send_frame(16, 8'h55, 8, 0, 0, 0, 0, 1, 2, 0);
        chk("R2", "single bad sample in bit 2", rx_data, 8'h55);
        pulse_rd();
        send_frame(16, 8'hAA, 8, 0, 0, 0, 0, 1, 7, 0);
        chk("R2", "single bad sample in bit 7", rx_data, 8'hAA);
        pulse_rd();
    endtask

    task automatic t_start_glitch();
        slots(1'b1, 16);
        slots(1'b0, 2);
        slots(1'b1, 24);
        chk("R3", "glitch loads nothing", rx_ready, 0);
        chk("R3", "glitch leaves data", rx_data, 8'hAA);
        send_frame(16, 8'h3C, 8, 0, 0, 0, 0, 1, -1, 0);
        chk("R3", "frame after glitch", rx_data, 8'h3C);
        pulse_rd();
    endtask

    task automatic t_parity();
        par_en = 1'b1; par_even = 1'b1;
        send_frame(16, 8'h07, 8, 0, 0, 1, par_bit(8'h07, 8, 0, 0, 1), 1, -1, 0);
        chk("R4", "even parity good", err_parity, 0);
        pulse_rd();
        send_frame(16, 8'h07, 8, 0, 0, 1, ~par_bit(8'h07, 8, 0, 0, 1), 1, -1, 0);
        chk("R4", "even parity bad", err_parity, 1);
        chk("R9", "err_any follows parity", err_any, 1);
        chk("R4", "data still loaded", rx_data, 8'h07);
        pulse_rd();
        pulse_clr();
        chk("R9", "clear parity", err_parity, 0);
        chk("R9", "err_any cleared", err_any, 0);
        par_even = 1'b0;
        send_frame(16, 8'h07, 8, 0, 0, 1, par_bit(8'h07, 8, 0, 0, 0), 1, -1, 0);
        chk("R4", "odd parity good", err_parity, 0);
        pulse_rd();
        addr_mode = 1'b1; par_even = 1'b1;
        send_frame(16, 8'h01, 8, 1, 1, 1, par_bit(8'h01, 8, 1, 1, 1), 1, -1, 0);
        chk("R4", "parity covers address bit", err_parity, 0);
        chk("R11", "address bit marks wake", wake_flag, 1);
        pulse_rd();
        addr_mode = 1'b0; par_en = 1'b0;
    endtask

    task automatic t_frame_break();
        send_frame(16, 8'h81, 8, 0, 0, 0, 0, 0, -1, 0);
        slots(1'b1, 16);
        chk("R5", "low stop flags framing", err_frame, 1);
        chk("R5", "data loaded with framing", rx_data, 8'h81);
        chk("R6", "short low no break", err_break, 0);
        pulse_rd();
        pulse_clr();
        send_frame(16, 8'h00, 8, 0, 0, 0, 0, 0, -1, 0);
        slots(1'b0, 84);
        slots(1'b1, 16);
        chk("R6", "long low flags break", err_break, 1);
        chk("R5", "break frame also framing", err_frame, 1);
        pulse_rd();
        pulse_clr();
    endtask

    task automatic t_overrun();
        send_frame(16, 8'h11, 8, 0, 0, 0, 0, 1, -1, 0);
        send_frame(16, 8'h22, 8, 0, 0, 0, 0, 1, -1, 0);
        chk("R7", "unread predecessor", err_overrun, 1);
        chk("R7", "newer data kept", rx_data, 8'h22);
        pulse_clr();
        chk("R9", "overrun cleared", err_overrun, 0);
    endtask

    task automatic t_collision();
        chk("R8", "ready pending before", rx_ready, 1);
        send_frame(16, 8'h33, 8, 0, 0, 0, 0, 1, -1, 1);
        chk("R8", "load wins over read", rx_ready, 1);
        chk("R8", "collided data", rx_data, 8'h33);
        chk("R7", "no overrun with read", err_overrun, 0);
        pulse_rd();
    endtask

    task automatic t_sleep_idle();
        addr_mode = 1'b0; sleep = 1'b1;
        send_frame(16, 8'h44, 8, 0, 0, 0, 0, 1, -1, 0);
        chk("R12", "short gap dropped", rx_ready, 0);
        chk("R12", "dropped data unchanged", rx_data, 8'h33);
        send_frame(88, 8'h5A, 8, 0, 0, 0, 0, 1, -1, 0);
        chk("R10", "long gap wakes", rx_ready, 1);
        chk("R10", "address data", rx_data, 8'h5A);
        chk("R10", "wake flag set", wake_flag, 1);
        pulse_rd();
        sleep = 1'b0;
        send_frame(16, 8'h66, 8, 0, 0, 0, 0, 1, -1, 0);
        chk("R12", "awake data frame", rx_data, 8'h66);
        chk("R12", "data frame not address", wake_flag, 0);
        pulse_rd();
    endtask

    task automatic t_sleep_addr();
        addr_mode = 1'b1; sleep = 1'b1;
        send_frame(88, 8'h12, 8, 1, 0, 0, 0, 1, -1, 0);
        chk("R11", "address bit 0 dropped despite gap", rx_ready, 0);
        chk("R12", "dropped keeps data", rx_data, 8'h66);
        send_frame(16, 8'h34, 8, 1, 1, 0, 0, 1, -1, 0);
        chk("R11", "address bit 1 taken", rx_ready, 1);
        chk("R11", "address value", rx_data, 8'h34);
        chk("R12", "wake on address", wake_flag, 1);
        pulse_rd();
        sleep = 1'b0;
        send_frame(16, 8'h56, 8, 1, 0, 0, 0, 1, -1, 0);
        chk("R11", "awake data frame", rx_data, 8'h56);
        chk("R12", "wake cleared for data", wake_flag, 0);
        pulse_rd();
        addr_mode = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_short_len();
        t_vote();
        t_start_glitch();
        t_parity();
        t_frame_break();
        t_overrun();
        t_collision();
        t_sleep_idle();
        t_sleep_addr();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule